// File: doc/BRIEF.md
# SD Host Normal-Interrupt Status Register

This block holds the sticky normal-interrupt status bits of an SD card host controller. It watches level status signals from the bus engine, buffer, DMA engine and card-detect logic. It turns selected edges of those signals into one-bit events. Each event is latched in a status bit only while that bit's status-enable bit is 1. A status bit stays set until software writes a 1 to it.

Software reaches three registers through a simple synchronous write port and a combinational read port:

| Address | Register | Access |
|---|---|---|
| 0 | status | write 1 to clear |
| 1 | status enable | read/write |
| 2 | signal enable | read/write |
| 3 | none | reads zero |

One interrupt line is raised while any status bit and its signal-enable bit are both 1.

Each event has its own set condition:
- Some events fire on a rising edge and others on a falling edge.
- Two events depend on the transfer direction.
- The block-gap event is gated by the stop-at-block-gap request.
- The two card-detect bits re-arm. If software clears one of them while the card state it reports still holds, the bit sets again.

Top module: `sd_irq_status`

## Requirements
- R1: Status bit 0 (command complete) sets in the cycle after `cmd_end` is 1 with `cmd_auto12` at 0. It does not set when `cmd_auto12` is 1.
- R2: Status bit 1 (transfer complete) sets on a falling edge of `rd_busy` when `xfer_rd` is 1. It sets on a falling edge of `dat_busy` when `xfer_rd` is 0.
- R3: Status bit 2 (block gap) sets only while `gap_stop_req` is 1. With `xfer_rd` at 1 it sets on a falling edge of `dat_busy`. With `xfer_rd` at 0 it sets on a falling edge of `wr_busy`.
- R4: Status bit 3 (DMA done) sets when `dma_done` is 1 and `dma_err` is 0. It stays clear when `dma_err` is 1.
- R5: Status bit 4 sets on a rising edge of `buf_wr_avail`. Status bit 5 sets on a rising edge of `buf_rd_avail`.
- R6: Status bit 6 sets on a rising edge of `card_present`, and status bit 7 sets on a falling edge of it. The card level held through reset produces no event afterwards.
- R7: After a write-1 clears bit 6 while `card_present` is 1, the bit sets again in the next cycle. Bit 7 behaves the same way while `card_present` is 0. Neither re-sets if its status-enable bit is 0.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set event and a clearing write meet in one cycle, the bit ends up set.
- R9: A status bit whose status-enable bit is 0 never sets.
- R10: `irq_o` is 1 exactly when some status bit and its signal-enable bit are both 1.
- R11: The register map is address 0 status, 1 status enable, 2 signal enable, with bits 7:0 used. Address 3 and all bits above 7 read 0, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Debounced card-inserted state |
| buf_rd_avail | input | 1 | Buffer has data ready to read |
| buf_wr_avail | input | 1 | Buffer has room to write |
| dat_busy | input | 1 | Data line active |
| wr_busy | input | 1 | Write transfer active |
| rd_busy | input | 1 | Read transfer active |
| cmd_end | input | 1 | Response end bit received (one-cycle strobe) |
| cmd_auto12 | input | 1 | The response belongs to an automatic stop command |
| dma_done | input | 1 | DMA finished (one-cycle strobe) |
| dma_err | input | 1 | DMA finished with an error |
| gap_stop_req | input | 1 | Stop-at-block-gap request |
| xfer_rd | input | 1 | 1 for a read transfer, 0 for a write transfer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `DATA_W` = 16 and `ADDR_W` = 2. The wider data word lets the bench write ones into bits 15:8 and confirm that they read back as zero and clear nothing. With the two-bit address, address 3 is a real, decoded location, so its read-zero behaviour gets exercised. Directed sequences cover the direction-dependent edges, the gap gating, the DMA error case, set-beats-clear and card re-arm. Seeded random traffic then toggles every level input and the enable masks against a bench model.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
    localparam int EV_N = 8;
    // status bit positions (software decodes these)
    localparam int EV_CC  = 0;
    localparam int EV_TC  = 1;
    localparam int EV_BG  = 2;
    localparam int EV_DMA = 3;
    localparam int EV_BWR = 4;
    localparam int EV_BRR = 5;
    localparam int EV_CIN = 6;
    localparam int EV_CRM = 7;

    // level inputs watched for edges
    localparam int LV_N    = 6;
    localparam int LV_CARD = 0;
    localparam int LV_BRD  = 1;
    localparam int LV_BWR  = 2;
    localparam int LV_DAT  = 3;
    localparam int LV_WRA  = 4;
    localparam int LV_RDA  = 5;
    // levels whose history reloads from the live input during reset
    localparam logic [LV_N-1:0] LV_KEEP = LV_N'(1) << LV_CARD;

    typedef logic [EV_N-1:0] ev_t;
    typedef logic [LV_N-1:0] lv_t;

    typedef struct packed {
        ev_t        st;
        ev_t        sten;
        ev_t        sien;
        logic [1:0] rearm;   // [0] insertion, [1] removal
    } regs_t;
endpackage

// File: rtl/sdis_edge.sv
module sdis_edge #(
    parameter int W = 6,
    parameter logic [W-1:0] KEEP_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = rst ? (lvl & KEEP_MASK) : lvl;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/sdis_evt.sv
module sdis_evt import sdis_pkg::*; (
    input  lv_t        lvl,
    input  lv_t        rise,
    input  lv_t        fall,
    input  logic       cmd_end,
    input  logic       cmd_auto12,
    input  logic       dma_done,
    input  logic       dma_err,
    input  logic       gap_stop_req,
    input  logic       xfer_rd,
    input  logic [1:0] rearm,
    output ev_t        set
);
    always_comb begin
        set          = '0;
        set[EV_CC]   = cmd_end & ~cmd_auto12;
        set[EV_TC]   = xfer_rd ? fall[LV_RDA] : fall[LV_DAT];
        set[EV_BG]   = gap_stop_req & (xfer_rd ? fall[LV_DAT] : fall[LV_WRA]);
        set[EV_DMA]  = dma_done & ~dma_err;
        set[EV_BWR]  = rise[LV_BWR];
        set[EV_BRR]  = rise[LV_BRD];
        set[EV_CIN]  = rise[LV_CARD] | (rearm[0] & lvl[LV_CARD]);
        set[EV_CRM]  = fall[LV_CARD] | (rearm[1] & ~lvl[LV_CARD]);
    end
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status import sdis_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_present,
    input  logic              buf_rd_avail,
    input  logic              buf_wr_avail,
    input  logic              dat_busy,
    input  logic              wr_busy,
    input  logic              rd_busy,
    input  logic              cmd_end,
    input  logic              cmd_auto12,
    input  logic              dma_done,
    input  logic              dma_err,
    input  logic              gap_stop_req,
    input  logic              xfer_rd,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STEN = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SIEN = ADDR_W'(2);

    lv_t   lvl, rise, fall;
    ev_t   set_v, clr_v;
    regs_t r_d, r_q;

    always_comb begin
        lvl          = '0;
        lvl[LV_CARD] = card_present;
        lvl[LV_BRD]  = buf_rd_avail;
        lvl[LV_BWR]  = buf_wr_avail;
        lvl[LV_DAT]  = dat_busy;
        lvl[LV_WRA]  = wr_busy;
        lvl[LV_RDA]  = rd_busy;
    end

    sdis_edge #(.W(LV_N), .KEEP_MASK(LV_KEEP)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    sdis_evt u_evt (
        .lvl          (lvl),
        .rise         (rise),
        .fall         (fall),
        .cmd_end      (cmd_end),
        .cmd_auto12   (cmd_auto12),
        .dma_done     (dma_done),
        .dma_err      (dma_err),
        .gap_stop_req (gap_stop_req),
        .xfer_rd      (xfer_rd),
        .rearm        (r_q.rearm),
        .set          (set_v)
    );

    always_comb begin
        clr_v = (reg_we && reg_addr == A_STAT) ? reg_wdata[EV_N-1:0] : '0;
        r_d   = r_q;
        // set beats clear; disabled bits never latch
        r_d.st    = (r_q.st & ~clr_v) | (set_v & r_q.sten);
        r_d.rearm = clr_v[EV_CRM:EV_CIN];
        if (reg_we && reg_addr == A_STEN) r_d.sten = reg_wdata[EV_N-1:0];
        if (reg_we && reg_addr == A_SIEN) r_d.sien = reg_wdata[EV_N-1:0];
        if (rst) r_d = '0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT:  reg_rdata[EV_N-1:0] = r_q.st;
            A_STEN:  reg_rdata[EV_N-1:0] = r_q.sten;
            A_SIEN:  reg_rdata[EV_N-1:0] = r_q.sien;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o = |(r_q.st & r_q.sien);

    // newly set bits must have been enabled
    p_en_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st & ~$past(r_q.st)) & ~$past(r_q.sten)) == '0);
    p_cmd_src_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.st[EV_CC]) |-> $past(cmd_end && !cmd_auto12));
    p_gap_req_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.st[EV_BG]) |-> $past(gap_stop_req));
    p_dma_ok_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.st[EV_DMA]) |-> $past(dma_done && !dma_err));
    // bits not written with 1 stay set
    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(r_q.st) & ~$past(clr_v)) & ~r_q.st) == '0);
    p_irq_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (reg_addr != A_STAT) || (reg_rdata != '0));
endmodule

// File: tb/sim_sd_irq_status.sv
`timescale 1ns/1ps
module sim_sd_irq_status;
    localparam int DW = 16;
    localparam int AW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic card = 1'b1, brd = 1'b0, bwr = 1'b0, dat = 1'b0, wra = 1'b0, rda = 1'b0;
    logic cmd_end = 1'b0, auto12 = 1'b0, dma_done = 1'b0, dma_err = 1'b0;
    logic gap = 1'b0, xrd = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic irq;

    int compared = 0;
    int mismatched = 0;

    logic [7:0] m_st, m_sten, m_sien;
    logic [1:0] m_rearm;
    logic [5:0] m_prev;   // 0 card,1 brd,2 bwr,3 dat,4 wra,5 rda

    always #10 clk = ~clk;

    sd_irq_status #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst),
        .card_present(card), .buf_rd_avail(brd), .buf_wr_avail(bwr),
        .dat_busy(dat), .wr_busy(wra), .rd_busy(rda),
        .cmd_end(cmd_end), .cmd_auto12(auto12), .dma_done(dma_done), .dma_err(dma_err),
        .gap_stop_req(gap), .xfer_rd(xrd),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one clock: model predicts from requirements, design is compared after the edge
    task automatic tick(input string tag);
        logic [5:0] cur, rs, fl;
        logic [7:0] s, c, nst;
        cur = {rda, wra, dat, bwr, brd, card};
        rs  = cur & ~m_prev;
        fl  = ~cur & m_prev;
        s[0] = cmd_end & ~auto12;
        s[1] = xrd ? fl[5] : fl[3];
        s[2] = gap & (xrd ? fl[3] : fl[4]);
        s[3] = dma_done & ~dma_err;
        s[4] = rs[2];
        s[5] = rs[1];
        s[6] = rs[0] | (m_rearm[0] & card);
        s[7] = fl[0] | (m_rearm[1] & ~card);
        c   = (we && addr == 0) ? wdata[7:0] : 8'h00;
        nst = (m_st & ~c) | (s & m_sten);
        @(posedge clk);
        #1;
        m_st    = nst;
        m_rearm = c[7:6];
        m_prev  = cur;
        if (we && addr == 1) m_sten = wdata[7:0];
        if (we && addr == 2) m_sien = wdata[7:0];
        if (addr == 0) check({tag, " status"}, rdata, {8'h00, m_st});
        check({tag, " irq R10"}, {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, |(m_st & m_sien)});
        @(negedge clk);
        we = 1'b0; cmd_end = 1'b0; auto12 = 1'b0; dma_done = 1'b0; dma_err = 1'b0;
        addr = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        we = 1'b1; addr = a; wdata = d;
        tick(tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
        addr = '0;
    endtask

    task automatic bit_is(input int b, input logic v, input string tag);
        addr = '0;
        #1;
        check(tag, {{(DW-1){1'b0}}, rdata[b]}, {{(DW-1){1'b0}}, v});
    endtask

    initial begin
        #(20ns * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_st = '0; m_sten = '0; m_sien = '0; m_rearm = '0;
        m_prev = {5'b0, card};

        // R11 reset state and map; R6 held card gives no event
        rd(2'd0, '0, "R11 reset status");
        rd(2'd1, '0, "R11 reset sten");
        rd(2'd2, '0, "R11 reset sien");
        wr(2'd1, 16'hFFFF, "R11 sten write");
        wr(2'd2, 16'hFF00, "R11 sien upper");
        rd(2'd1, 16'h00FF, "R11 sten readback");
        rd(2'd2, 16'h0000, "R11 sien upper bits");
        rd(2'd3, 16'h0000, "R11 addr3");
        tick("R6 no event after reset");
        bit_is(6, 1'b0, "R6 no insert after reset");

        // R9 disabled bit
        wr(2'd1, 16'h00FE, "R9 disable bit0");
        cmd_end = 1'b1; tick("R9");
        bit_is(0, 1'b0, "R9 disabled stays clear");
        wr(2'd1, 16'h00FF, "R9 reenable");

        // R1 auto stop response
        cmd_end = 1'b1; auto12 = 1'b1; tick("R1 auto");
        bit_is(0, 1'b0, "R1 auto12 no set");
        cmd_end = 1'b1; tick("R1 normal");
        bit_is(0, 1'b1, "R1 set");

        // R8 write 0 keeps, collision favours set
        wr(2'd0, 16'hFF00, "R8 write zeros");
        bit_is(0, 1'b1, "R8 write 0 no effect");
        cmd_end = 1'b1; we = 1'b1; addr = 2'd0; wdata = 16'h0001; tick("R8 collision");
        bit_is(0, 1'b1, "R8 set wins");
        wr(2'd0, 16'h0001, "R8 clear");
        bit_is(0, 1'b0, "R8 cleared");

        // R10 masking
        wr(2'd2, 16'h0000, "R10 mask off");
        cmd_end = 1'b1; tick("R10 masked");
        check("R10 masked irq", {{(DW-1){1'b0}}, irq}, '0);
        wr(2'd2, 16'h00FF, "R10 unmask");
        check("R10 unmasked irq", {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, 1'b1});
        wr(2'd0, 16'h00FF, "clear all");

        // R4 DMA
        dma_done = 1'b1; dma_err = 1'b1; tick("R4 err");
        bit_is(3, 1'b0, "R4 error no set");
        dma_done = 1'b1; tick("R4 ok");
        bit_is(3, 1'b1, "R4 set");

        // R2 / R3 direction-dependent edges
        xrd = 1'b1; rda = 1'b1; dat = 1'b1; tick("R2 rd up");
        rda = 1'b0; tick("R2 rd down");
        bit_is(1, 1'b1, "R2 read complete");
        dat = 1'b0; tick("R3 no req");
        bit_is(2, 1'b0, "R3 gap without request");
        gap = 1'b1; dat = 1'b1; tick("R3 up");
        dat = 1'b0; tick("R3 read gap");
        bit_is(2, 1'b1, "R3 read gap set");
        wr(2'd0, 16'h00FF, "clear all");
        xrd = 1'b0; wra = 1'b1; dat = 1'b1; tick("R3 wr up");
        wra = 1'b0; tick("R3 wr down");
        bit_is(2, 1'b1, "R3 write gap set");
        bit_is(1, 1'b0, "R2 no tc on wr_busy");
        dat = 1'b0; tick("R2 wr down");
        bit_is(1, 1'b1, "R2 write complete");
        gap = 1'b0;

        // R5 buffers
        bwr = 1'b1; brd = 1'b1; tick("R5 up");
        bit_is(4, 1'b1, "R5 write ready");
        bit_is(5, 1'b1, "R5 read ready");

        // R6 / R7 card
        wr(2'd0, 16'h00FF, "clear all");
        wr(2'd0, 16'h0040, "R7 clear insert");
        tick("R7 rearm");
        bit_is(6, 1'b1, "R7 insert re-sets");
        wr(2'd1, 16'h00BF, "R7 disable insert");
        wr(2'd0, 16'h0040, "R7 clear again");
        tick("R7 stay");
        bit_is(6, 1'b0, "R7 disabled no re-set");
        wr(2'd1, 16'h00FF, "reenable");
        card = 1'b0; tick("R6 removal");
        bit_is(7, 1'b1, "R6 removal set");
        wr(2'd0, 16'h0080, "R7 clear removal");
        tick("R7 rearm removal");
        bit_is(7, 1'b1, "R7 removal re-sets");
        card = 1'b1; tick("R6 insert");
        bit_is(6, 1'b1, "R6 insertion set");

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 16) == 0) card = ~card;
            brd = $urandom; bwr = $urandom; dat = $urandom; wra = $urandom; rda = $urandom;
            gap = $urandom; xrd = $urandom;
            cmd_end = $urandom; auto12 = $urandom; dma_done = $urandom; dma_err = $urandom;
            if ((n % 250) == 0) begin
                we = 1'b1; addr = AW'(1 + ($urandom % 2)); wdata = DW'($urandom);
            end else if (($urandom % 6) == 0) begin
                we = 1'b1; addr = '0; wdata = DW'($urandom);
            end
            tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule